// File: doc/BRIEF.md
# DRAM Refresh Timer and Strobe Sequencer

This block produces DRAM refresh cycles on a fixed schedule. An interval counter runs while refresh is enabled. Each time it expires, a refresh is marked pending and a request goes to the memory arbiter. Once the arbiter grants the bus, the block drives the active-low row and column strobes. In EDO/normal DRAM mode it uses a column-before-row refresh. In SDRAM mode it issues a single refresh command and then waits out the row cycle time. It signals the end of each refresh with a one-cycle done pulse.

The interval length, the setup and hold codes and the memory mode are sampled only when the interval counter reloads. The strobe sequencer then takes its own copy of that configuration when a sequence starts. A configuration write therefore never alters a strobe sequence that is already under way. If an interval runs out while a refresh is still waiting for the bus, that refresh is dropped and a sticky status bit records the loss.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `refresh_en_i` is 0, `refresh_req_o` never rises and the interval counter keeps its value. Disabled cycles lengthen the running interval by exactly their number.
- R2: Two successive interval expiries are 2^11 − `count_val_i` + 1 clock cycles apart. For example, a value of 2029 gives a period of 20 cycles.
- R3: After an expiry, `refresh_req_o` stays at 1 until a cycle in which `refresh_gnt_i` is 1 while the sequencer is idle. The strobe sequence starts in the cycle that follows that grant.
- R4: An expiry that occurs while a refresh is still pending sets `missed_o`, which then stays at 1 until reset. No second refresh is queued, so `refresh_req_o` is 0 after the grant.
- R5: In DRAM mode (`sdram_mode_i` = 0), `cas_n_o` goes low before `ras_n_o`. The number of cycles with `cas_n_o` = 0 and `ras_n_o` = 1 is 1 when `setup_code_i` = 0 and 2 when it is 1.
- R6: In DRAM mode, `ras_n_o` stays low together with `cas_n_o` for `hold_code_i` + 1 cycles for codes 0 to 4. Codes 5, 6 and 7 are clamped to 5 cycles.
- R7: After each strobe sequence, both strobes are high and `refresh_done_o` is 1 for exactly one cycle. `busy_o` is 1 from the first strobe cycle until the cycle before done, so it lasts setup + hold cycles in DRAM mode.
- R8: In SDRAM mode, `ras_n_o` and `cas_n_o` go low together for exactly one cycle, and `setup_code_i` is ignored. `busy_o` then lasts `hold_code_i` + 1 cycles for codes 0 to 5, and codes 6 and 7 are clamped to 6 cycles.
- R9: Changes to `count_val_i`, the codes or the mode take effect only at the next interval reload. The interval that is running and any pending or active sequence keep the values latched earlier.
- R10: After reset, `refresh_req_o`, `refresh_done_o`, `busy_o` and `missed_o` are 0, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_en_i | input | 1 | Enables refresh scheduling |
| count_val_i | input | 11 | Interval value; period = 2^11 − value + 1 |
| hold_code_i | input | 3 | Column hold code (DRAM) or row cycle code (SDRAM) |
| setup_code_i | input | 1 | Column setup: 0 = 1 cycle, 1 = 2 cycles (DRAM only) |
| sdram_mode_i | input | 1 | 0 = EDO/normal DRAM, 1 = SDRAM |
| refresh_gnt_i | input | 1 | Bus grant from the arbiter |
| refresh_req_o | output | 1 | Refresh pending, request to the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| refresh_done_o | output | 1 | One-cycle pulse at the end of a refresh |
| busy_o | output | 1 | Strobe sequence in progress |
| missed_o | output | 1 | Sticky flag: a refresh was dropped |

## Verification
The bench times the gap between request rises in three situations: directly after a new interval value is written, across a stretch with refresh disabled, and with a small period. A counter that reloaded from the live input would cut the running interval short. A counter that freed itself while disabled would raise its request early. The bench measures each strobe segment under every hold code, including the clamped ones. An unclamped code would stretch or stall the sequence, and in SDRAM mode a setup time that was wrongly honoured would add a column-only cycle. The bench also holds back the grant past a second expiry, to catch a design that queues the extra refresh or clears the missed flag. Finally, it changes the codes at the moment of the grant, to catch a sequencer that reads live inputs.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int CODE_W        = 3;
  localparam int LEN_W         = 3;
  localparam int DRAM_HOLD_MAX = 5;
  localparam int SDRAM_RC_MAX  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_CMD,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic             sdram;
    logic [1:0]       setup_len;
    logic [LEN_W-1:0] tail_len;  // column hold or row cycle length
  } seq_cfg_t;

  localparam seq_cfg_t CFG_RESET = '{sdram: 1'b0, setup_len: 2'd1, tail_len: LEN_W'(1)};
endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] count_val_i,
  output logic             reload_o,
  output logic             expire_o
);
  localparam int TW = CNT_W + 1;
  localparam logic [TW-1:0] FULL = TW'(1) << CNT_W;

  logic [TW-1:0] cnt_q;
  logic          armed_q;
  logic [TW-1:0] reload_val;

  // period - 1 = 2^CNT_W - value
  assign reload_val = FULL - {1'b0, count_val_i};
  assign expire_o   = en_i & armed_q & (cnt_q == '0);
  assign reload_o   = en_i & (~armed_q | (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (en_i) begin
      if (reload_o) begin
        cnt_q   <= reload_val;
        armed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - TW'(1);
      end
    end
  end
endmodule

// File: rtl/drs_cfg_latch.sv
module drs_cfg_latch
  import drs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sdram_i,
  input  logic              setup_code_i,
  input  logic [CODE_W-1:0] hold_code_i,
  output seq_cfg_t          cfg_o
);
  seq_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d.sdram     = sdram_i;
    cfg_d.setup_len = (setup_code_i && !sdram_i) ? 2'd2 : 2'd1;
    if (sdram_i)
      cfg_d.tail_len = (int'(hold_code_i) >= SDRAM_RC_MAX) ? LEN_W'(SDRAM_RC_MAX)
                                                          : LEN_W'(hold_code_i) + LEN_W'(1);
    else
      cfg_d.tail_len = (int'(hold_code_i) >= DRAM_HOLD_MAX) ? LEN_W'(DRAM_HOLD_MAX)
                                                           : LEN_W'(hold_code_i) + LEN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_RESET;
    else if (load_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/drs_strobe_fsm.sv
module drs_strobe_fsm
  import drs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  seq_cfg_t cfg_i,
  output logic     ras_n_o,
  output logic     cas_n_o,
  output logic     done_o,
  output logic     busy_o,
  output logic     idle_o
);
  seq_state_e       state_q;
  seq_cfg_t         snap_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      snap_q  <= CFG_RESET;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          snap_q <= cfg_i;
          if (cfg_i.sdram) state_q <= ST_CMD;
          else begin
            state_q <= ST_SETUP;
            cnt_q   <= LEN_W'(cfg_i.setup_len) - LEN_W'(1);
          end
        end
        ST_SETUP: if (cnt_q == '0) begin
          state_q <= ST_STROBE;
          cnt_q   <= snap_q.tail_len - LEN_W'(1);
        end else cnt_q <= cnt_q - LEN_W'(1);
        ST_STROBE: if (cnt_q == '0) state_q <= ST_DONE;
                   else cnt_q <= cnt_q - LEN_W'(1);
        ST_CMD: if (snap_q.tail_len == LEN_W'(1)) state_q <= ST_DONE;
        else begin
          state_q <= ST_WAIT;
          cnt_q   <= snap_q.tail_len - LEN_W'(2);
        end
        ST_WAIT: if (cnt_q == '0) state_q <= ST_DONE;
                 else cnt_q <= cnt_q - LEN_W'(1);
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cas_n_o = !(state_q == ST_SETUP || state_q == ST_STROBE || state_q == ST_CMD);
  assign ras_n_o = !(state_q == ST_STROBE || state_q == ST_CMD);
  assign done_o  = (state_q == ST_DONE);
  assign idle_o  = (state_q == ST_IDLE);
  assign busy_o  = !idle_o && !done_o;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              refresh_en_i,
  input  logic [CNT_W-1:0]  count_val_i,
  input  logic [CODE_W-1:0] hold_code_i,
  input  logic              setup_code_i,
  input  logic              sdram_mode_i,
  input  logic              refresh_gnt_i,
  output logic              refresh_req_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              refresh_done_o,
  output logic              busy_o,
  output logic              missed_o
);
  logic     reload, expire, take, seq_idle;
  logic     pend_q, missed_q;
  seq_cfg_t cfg;

  drs_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (refresh_en_i),
    .count_val_i (count_val_i),
    .reload_o    (reload),
    .expire_o    (expire)
  );

  drs_cfg_latch u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (reload),
    .sdram_i      (sdram_mode_i),
    .setup_code_i (setup_code_i),
    .hold_code_i  (hold_code_i),
    .cfg_o        (cfg)
  );

  assign take = pend_q & refresh_gnt_i & seq_idle;

  // a new expiry wins over a grant in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      pend_q   <= expire | (pend_q & ~take);
      missed_q <= missed_q | (expire & pend_q & ~take);
    end
  end

  drs_strobe_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (take),
    .cfg_i   (cfg),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .done_o  (refresh_done_o),
    .busy_o  (busy_o),
    .idle_o  (seq_idle)
  );

  assign refresh_req_o = pend_q;
  assign missed_o      = missed_q;
endmodule

// File: rtl/drs_checker.sv
module drs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic refresh_en_i,
  input logic refresh_gnt_i,
  input logic refresh_req_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic refresh_done_o,
  input logic busy_o,
  input logic missed_o
);
  // R1
  no_req_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refresh_req_o) |-> $past(refresh_en_i));

  // R3
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_req_o && !refresh_gnt_i) |=> refresh_req_o);

  // R4
  missed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missed_o |=> missed_o);

  // R5
  cas_with_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_done_o |=> !refresh_done_o);

  // R7
  done_idle_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_done_o |-> (ras_n_o && cas_n_o && !busy_o));

  // R7
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refresh_done_o) |-> $past(busy_o));
endmodule

bind dram_refresh_seq drs_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .refresh_en_i   (refresh_en_i),
  .refresh_gnt_i  (refresh_gnt_i),
  .refresh_req_o  (refresh_req_o),
  .ras_n_o        (ras_n_o),
  .cas_n_o        (cas_n_o),
  .refresh_done_o (refresh_done_o),
  .busy_o         (busy_o),
  .missed_o       (missed_o)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [10:0] cval = 11'd2029;
  logic [2:0]  hcode = 3'd0;
  logic        scode = 1'b0;
  logic        sdram = 1'b0;
  logic        gnt = 1'b0;
  logic        req, ras_n, cas_n, done, busy, missed;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dram_refresh_seq u_dram_refresh_seq (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .refresh_en_i   (en),
    .count_val_i    (cval),
    .hold_code_i    (hcode),
    .setup_code_i   (scode),
    .sdram_mode_i   (sdram),
    .refresh_gnt_i  (gnt),
    .refresh_req_o  (req),
    .ras_n_o        (ras_n),
    .cas_n_o        (cas_n),
    .refresh_done_o (done),
    .busy_o         (busy),
    .missed_o       (missed)
  );

  // {sdram, setup, code, exp_setup_cycles, exp_ras_cycles, exp_busy_cycles}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 2'd1, 3'd1, 3'd2},
    {1'b0, 1'b1, 3'd0, 2'd2, 3'd1, 3'd3},
    {1'b0, 1'b0, 3'd1, 2'd1, 3'd2, 3'd3},
    {1'b0, 1'b1, 3'd2, 2'd2, 3'd3, 3'd5},
    {1'b0, 1'b0, 3'd3, 2'd1, 3'd4, 3'd5},
    {1'b0, 1'b1, 3'd4, 2'd2, 3'd5, 3'd7},
    {1'b0, 1'b0, 3'd5, 2'd1, 3'd5, 3'd6},
    {1'b0, 1'b1, 3'd7, 2'd2, 3'd5, 3'd7},
    {1'b1, 1'b1, 3'd0, 2'd0, 3'd1, 3'd1},
    {1'b1, 1'b0, 3'd2, 2'd0, 3'd1, 3'd3},
    {1'b1, 1'b1, 3'd5, 2'd0, 3'd1, 3'd6},
    {1'b1, 1'b0, 3'd7, 2'd0, 3'd1, 3'd6}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_req();
    int g = 0;
    while (!req && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // grant at a request rise and count cycles to the next rise
  task automatic grant_and_time(output int n);
    gnt = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      gnt = 1'b0;
    end while (!req && n < 5000);
  endtask

  task automatic measure(output int su, output int rs, output int bz,
                         output int dn, output int both);
    su = 0; rs = 0; bz = 0; dn = 0; both = 0;
    gnt = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      gnt = 1'b0;
      if (!cas_n && ras_n) su++;
      if (!ras_n) rs++;
      if (!ras_n && !cas_n) both++;
      if (busy) bz++;
      if (done) dn++;
    end
  endtask

  // consume one stale refresh, then wait for a fresh one
  task automatic fresh_req();
    int k;
    wait_req();
    grant_and_time(k);
    if (k < 12) repeat (12 - k) @(negedge clk);
    wait_req();
  endtask

  initial begin
    int n, su, rs, bz, dn, both;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 req", int'(req), 0);
    chk("R10 ras_n", int'(ras_n), 1);
    chk("R10 cas_n", int'(cas_n), 1);
    chk("R10 done/busy", int'(done | busy), 0);
    chk("R10 missed", int'(missed), 0);
    rst_n = 1'b1;

    // R1 disabled: no request
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      n += int'(req);
    end
    chk("R1 no req while disabled", n, 0);

    en = 1'b1;
    wait_req();
    grant_and_time(n);
    chk("R2 period 20", n, 20);
    cval = 11'd2039;            // period 10 from next reload
    grant_and_time(n);
    chk("R9 running interval unchanged", n, 20);
    grant_and_time(n);
    chk("R2 period 10", n, 10);
    cval = 11'd2029;
    grant_and_time(n);
    chk("R9 period 10 until reload", n, 10);

    // R1 hold: disabled cycles stretch the interval
    gnt = 1'b1;
    n = 0;
    repeat (5) begin
      @(negedge clk);
      n++;
      gnt = 1'b0;
    end
    en = 1'b0;
    su = 0;
    repeat (30) begin
      @(negedge clk);
      n++;
      su += int'(req);
    end
    chk("R1 req low while disabled", su, 0);
    en = 1'b1;
    while (!req && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R1 counter held", n, 50);

    // R3 request held until grant
    su = 0;
    repeat (8) begin
      @(negedge clk);
      su += int'(req);
    end
    chk("R3 req held", su, 8);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    chk("R3 req cleared by grant", int'(req), 0);
    chk("R3 sequence started", int'(busy), 1);

    // R4 missed refresh
    wait_req();
    repeat (23) @(negedge clk);
    chk("R4 missed set", int'(missed), 1);
    chk("R4 req still set", int'(req), 1);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    su = 0;
    repeat (10) begin
      @(negedge clk);
      su += int'(req);
    end
    chk("R4 no queued refresh", su, 0);
    chk("R4 missed sticky", int'(missed), 1);

    // table of strobe configurations
    for (int v = 0; v < NV; v++) begin
      sdram = VEC[v][12];
      scode = VEC[v][11];
      hcode = VEC[v][10:8];
      fresh_req();
      measure(su, rs, bz, dn, both);
      if (VEC[v][12]) begin
        chk($sformatf("R8 v%0d cmd cycles", v), rs, int'(VEC[v][5:3]));
        chk($sformatf("R8 v%0d setup ignored", v), su, 0);
        chk($sformatf("R8 v%0d busy", v), bz, int'(VEC[v][2:0]));
      end else begin
        chk($sformatf("R5 v%0d setup", v), su, int'(VEC[v][7:6]));
        chk($sformatf("R6 v%0d hold", v), rs, int'(VEC[v][5:3]));
        chk($sformatf("R6 v%0d cas with ras", v), both, int'(VEC[v][5:3]));
        chk($sformatf("R7 v%0d busy", v), bz, int'(VEC[v][2:0]));
      end
      chk($sformatf("R7 v%0d done pulses", v), dn, 1);
    end

    // R9 codes changed at grant do not touch the latched sequence
    sdram = 1'b0; scode = 1'b1; hcode = 3'd4;
    fresh_req();
    scode = 1'b0; hcode = 3'd0; sdram = 1'b1;
    measure(su, rs, bz, dn, both);
    chk("R9 setup latched", su, 2);
    chk("R9 hold latched", rs, 5);
    chk("R9 done", dn, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule